// File: doc/BRIEF.md
# Multicycle RISC Processor Core

This block is a 32-bit processor core that spends several clock cycles on each instruction. One arithmetic unit serves every step: it advances the program counter, forms branch targets, computes load and store addresses and does the register-to-register arithmetic. One memory port carries both instruction fetches and data accesses. A control state machine steps through five phases: fetch, decode with register read, execute, memory access, and write-back. Each instruction uses only the phases it needs, so it takes between two and five cycles.

The core supports a small instruction subset: register-to-register add, subtract, AND, OR and signed set-less-than, plus word load, word store and branch-if-equal. The program counter is advanced during fetch. The branch target is computed in the decode cycle, before the opcode is known. A branch therefore resolves in its execute cycle and ends there. The register file has 32 entries, and entry 0 always reads as zero.

The memory port uses byte addresses that are always word aligned, and bits 1:0 are always zero. Memory reads are combinational within a cycle, and a write takes effect at the clock edge on which the write enable is high.

Top module: `mcyc_core`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `mem_addr` is 0 and `mem_we` is 0. The first instruction fetched after reset is the one at byte address 0.
- R2: Every instruction starts with a fetch cycle. In that cycle the word at the program counter is read into the instruction register, and the program counter is written with itself plus 4.
- R3: In the decode cycle, operand A is read from the register in bits 25:21 and operand B from the register in bits 20:16. Also in that cycle, the branch target (PC+4 plus the sign-extended bits 15:0 times 4) is captured, whatever the opcode.
- R4: Opcode 0x00 in bits 31:26, with bits 10:6 equal to zero, is a register-to-register instruction. Bits 5:0 select the operation: 0x20 add, 0x22 subtract (A-B), 0x24 AND, 0x25 OR. The result is written to the register in bits 15:11 in the fourth cycle, so the instruction takes 4 cycles.
- R5: Opcode 0x23 loads the word at A plus the sign-extended bits 15:0 into the register in bits 20:16 in the fifth cycle, so a load takes 5 cycles.
- R6: Opcode 0x2B stores B to the address A plus the sign-extended bits 15:0 in the fourth cycle, so a store takes 4 cycles.
- R7: Opcode 0x04 compares A and B in the third cycle. If they are equal, the program counter is loaded with the branch target. Either way the instruction ends after 3 cycles.
- R8: A write to register 0 is discarded, and register 0 always reads as 0.
- R9: An unknown opcode, or an unknown function code under opcode 0x00, writes no register and no memory, and is followed by a fetch after 2 cycles.
- R10: Function code 0x2A writes 1 to the register in bits 15:11 when A is less than B as signed two's-complement values, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Byte address of the memory word accessed this cycle (word aligned) |
| mem_wdata | output | 32 | Data to write to memory |
| mem_we | output | 1 | Memory write enable; the write takes effect on the next rising edge |
| mem_rdata | input | 32 | Word read from `mem_addr`, valid within the same cycle |

## Verification
The assertions assume that memory returns a defined word for every address the core presents. They also assume that data written by a store is visible when that address is next read. The bench gives both by modelling memory as a small array, read combinationally and written at the clock edge. The bench runs one fixed program, and it only touches addresses inside that array. The program uses register 0 as the only base register and puts its data words above the code, so a fetch address can never be mistaken for a data address. It is rerun over a sweep of operand pairs: ordinary, equal, zero, sign-crossing and overflow-prone pairs.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  localparam int XLEN      = 32;
  localparam int REG_N     = 32;
  localparam int REG_AW    = $clog2(REG_N);
  localparam int WORD_BYTES = XLEN / 8;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_EXEC, S_MEM, S_WB
  } mc_state_t;

  typedef enum logic [2:0] {
    C_ARITH, C_LOAD, C_STORE, C_BEQ, C_BAD
  } mc_class_t;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] imm);
    return {{(XLEN-16){imm[15]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] br_offset(input logic [15:0] imm);
    return sext16(imm) << 2;
  endfunction

  function automatic logic fn_known(input logic [5:0] fn);
    return (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_AND) ||
           (fn == FN_OR)  || (fn == FN_SLT);
  endfunction

  function automatic mc_class_t classify(input logic [5:0] op,
                                         input logic [4:0] shamt,
                                         input logic [5:0] fn);
    mc_class_t c;
    case (op)
      OP_RTYPE: c = (fn_known(fn) && shamt == 5'd0) ? C_ARITH : C_BAD;
      OP_LOAD:  c = C_LOAD;
      OP_STORE: c = C_STORE;
      OP_BEQ:   c = C_BEQ;
      default:  c = C_BAD;
    endcase
    return c;
  endfunction

  function automatic alu_op_t fn_to_op(input logic [5:0] fn);
    alu_op_t o;
    case (fn)
      FN_SUB:  o = ALU_SUB;
      FN_AND:  o = ALU_AND;
      FN_OR:   o = ALU_OR;
      FN_SLT:  o = ALU_SLT;
      default: o = ALU_ADD;
    endcase
    return o;
  endfunction

  function automatic logic [XLEN-1:0] alu_calc(input alu_op_t op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      ALU_SUB: r = a - b;
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_SLT: r = ($signed(a) < $signed(b)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
      default: r = a + b;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mcyc_regfile.sv
module mcyc_regfile
  import mcyc_pkg::*;
#(
  parameter int N  = REG_N,
  parameter int AW = REG_AW,
  parameter int W  = XLEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [N];

  // Entry 0 is a constant; entries 1..N-1 are storage.
  assign regs[0] = '0;

  for (genvar g = 1; g < N; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             regs[g] <= '0;
      else if (we && wa == AW'(g))            regs[g] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];

  // R8
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra1 == '0) |-> (rd1 == '0));
  // R8
  zero_read2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa == '0 && ra2 == '0) |=> (regs[0] == '0));
endmodule

// File: rtl/mcyc_alu.sv
module mcyc_alu
  import mcyc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_t      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  assign y = alu_calc(op, a, b);
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  mc_class_t cls,
  input  logic      a_eq_b,
  output mc_state_t st,
  output logic      ev_fetch,
  output logic      ev_decode,
  output logic      ev_exec,
  output logic      take_branch,
  output logic      store_now,
  output logic      load_read,
  output logic      arith_wr,
  output logic      load_wr
);
  mc_state_t nx;

  always_comb begin
    nx = S_FETCH;
    case (st)
      S_FETCH:  nx = S_DECODE;
      S_DECODE: nx = (cls == C_BAD) ? S_FETCH : S_EXEC;
      S_EXEC:   nx = (cls == C_BEQ) ? S_FETCH : S_MEM;
      S_MEM:    nx = (cls == C_LOAD) ? S_WB : S_FETCH;
      S_WB:     nx = S_FETCH;
      default:  nx = S_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_FETCH;
    else        st <= nx;
  end

  assign ev_fetch    = (st == S_FETCH);
  assign ev_decode   = (st == S_DECODE);
  assign ev_exec     = (st == S_EXEC);
  assign take_branch = ev_exec && (cls == C_BEQ) && a_eq_b;
  assign store_now   = (st == S_MEM) && (cls == C_STORE);
  assign load_read   = (st == S_MEM) && (cls == C_LOAD);
  assign arith_wr    = (st == S_MEM) && (cls == C_ARITH);
  assign load_wr     = (st == S_WB);

  // R2
  decode_follows_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch |=> ev_decode);
  // R9
  bad_op_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_decode && cls == C_BAD) |=> ev_fetch);
  // R7
  branch_three_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_exec && cls == C_BEQ) |=> ev_fetch);
  // R6
  store_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_now |=> ev_fetch);
  // R4
  arith_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arith_wr |=> ev_fetch);
  // R5
  load_wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |-> $past(load_read));
endmodule

// File: rtl/mcyc_core.sv
module mcyc_core
  import mcyc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we,
  input  logic [XLEN-1:0] mem_rdata
);
  logic [XLEN-1:0] pc, ir, a_q, b_q, alu_q, mdr;
  logic [XLEN-1:0] rf_rd1, rf_rd2, alu_a, alu_b, alu_y, rf_wd;
  logic [REG_AW-1:0] rf_wa;
  logic rf_we;
  alu_op_t alu_op;
  mc_state_t st;
  mc_class_t cls;
  logic ev_fetch, ev_decode, ev_exec, take_branch;
  logic store_now, load_read, arith_wr, load_wr;

  wire [5:0]        f_op    = ir[31:26];
  wire [REG_AW-1:0] f_rs    = ir[25:21];
  wire [REG_AW-1:0] f_rt    = ir[20:16];
  wire [REG_AW-1:0] f_rd    = ir[15:11];
  wire [4:0]        f_shamt = ir[10:6];
  wire [5:0]        f_fn    = ir[5:0];
  wire [15:0]       f_imm   = ir[15:0];

  assign cls = classify(f_op, f_shamt, f_fn);
  wire a_eq_b = (a_q == b_q);

  mcyc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cls(cls), .a_eq_b(a_eq_b), .st(st),
    .ev_fetch(ev_fetch), .ev_decode(ev_decode), .ev_exec(ev_exec),
    .take_branch(take_branch), .store_now(store_now), .load_read(load_read),
    .arith_wr(arith_wr), .load_wr(load_wr)
  );

  // Shared ALU operand selection per phase.
  always_comb begin
    alu_a  = pc;
    alu_b  = '0;
    alu_op = ALU_ADD;
    case (st)
      S_FETCH:  alu_b = XLEN'(WORD_BYTES);
      S_DECODE: alu_b = br_offset(f_imm);
      S_EXEC: begin
        alu_a = a_q;
        if (cls == C_ARITH) begin
          alu_b  = b_q;
          alu_op = fn_to_op(f_fn);
        end else begin
          alu_b = sext16(f_imm);
        end
      end
      default: ;
    endcase
  end

  mcyc_alu u_alu (.op(alu_op), .a(alu_a), .b(alu_b), .y(alu_y));

  assign rf_we = arith_wr || load_wr;
  assign rf_wa = load_wr ? f_rt : f_rd;
  assign rf_wd = load_wr ? mdr : alu_q;

  mcyc_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .ra1(f_rs), .ra2(f_rt),
    .rd1(rf_rd1), .rd2(rf_rd2), .we(rf_we), .wa(rf_wa), .wd(rf_wd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      ir    <= '0;
      a_q   <= '0;
      b_q   <= '0;
      alu_q <= '0;
      mdr   <= '0;
    end else begin
      if (ev_fetch) begin
        ir <= mem_rdata;
        pc <= alu_y;
      end
      if (take_branch) pc <= alu_q;
      if (ev_decode) begin
        a_q <= rf_rd1;
        b_q <= rf_rd2;
      end
      if (ev_decode || (ev_exec && cls != C_BEQ)) alu_q <= alu_y;
      if (load_read) mdr <= mem_rdata;
    end
  end

  assign mem_addr  = ev_fetch ? pc : alu_q;
  assign mem_wdata = b_q;
  assign mem_we    = store_now;

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch |=> (pc == $past(pc) + XLEN'(WORD_BYTES)));
  // R3
  target_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_decode |=> (alu_q == $past(pc) + br_offset($past(f_imm))));
  // R7
  branch_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_branch |=> (pc == $past(alu_q)));
  // R7
  branch_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_exec && cls == C_BEQ && !a_eq_b) |=> $stable(pc));
  // R9
  bad_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_decode && cls == C_BAD) |=> (!rf_we && !mem_we));
  // R1
  aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[1:0] == 2'b00 || !ev_fetch);
endmodule

// File: tb/sim_mcyc_core.sv
module sim_mcyc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic [31:0] mem [64];
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  mcyc_core u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;

  localparam logic [31:0] SENT = 32'hBAD0_BAD0;
  localparam int HALT_ADDR = 88;

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                        input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic load_prog(input logic [31:0] va, input logic [31:0] vb);
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[0]  = enc_i(6'h23, 0, 1, 16'h0080);
    mem[1]  = enc_i(6'h23, 0, 2, 16'h0084);
    mem[2]  = enc_r(1, 2, 3, 6'h20);
    mem[3]  = enc_r(1, 2, 4, 6'h22);
    mem[4]  = enc_r(1, 2, 5, 6'h24);
    mem[5]  = enc_r(1, 2, 6, 6'h25);
    mem[6]  = enc_r(1, 2, 7, 6'h2A);
    mem[7]  = enc_r(2, 1, 8, 6'h2A);
    mem[8]  = enc_i(6'h2B, 0, 3, 16'h00A0);
    mem[9]  = enc_i(6'h2B, 0, 4, 16'h00A4);
    mem[10] = enc_i(6'h2B, 0, 5, 16'h00A8);
    mem[11] = enc_i(6'h2B, 0, 6, 16'h00AC);
    mem[12] = enc_i(6'h2B, 0, 7, 16'h00B0);
    mem[13] = enc_i(6'h2B, 0, 8, 16'h00B4);
    mem[14] = enc_r(1, 2, 0, 6'h20);
    mem[15] = enc_i(6'h2B, 0, 0, 16'h00B8);
    mem[16] = enc_i(6'h04, 1, 2, 16'h0001);
    mem[17] = enc_i(6'h2B, 0, 1, 16'h00BC);
    mem[18] = enc_i(6'h04, 0, 0, 16'h0001);
    mem[19] = enc_i(6'h2B, 0, 1, 16'h00C0);
    mem[20] = {6'h3F, 26'h0};
    mem[21] = enc_i(6'h2B, 0, 2, 16'h00C4);
    mem[22] = enc_i(6'h04, 0, 0, 16'hFFFF);
    mem[32] = va;
    mem[33] = vb;
    for (int i = 40; i < 50; i++) mem[i] = SENT;
  endtask

  task automatic run_pair(input logic [31:0] va, input logic [31:0] vb);
    int halt_cyc = -1;
    int exp_halt;
    logic [31:0] lt_ab, lt_ba;
    @(negedge clk);
    rst_n = 1'b0;
    load_prog(va, vb);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: first fetch after reset is at address 0
    chk("R1 first fetch addr", mem_addr, 32'h0);
    for (int cyc = 0; cyc < 140; cyc++) begin
      if (halt_cyc < 0 && mem_addr == HALT_ADDR) halt_cyc = cyc;
      @(negedge clk);
      #1;
    end
    lt_ab = ($signed(va) < $signed(vb)) ? 32'd1 : 32'd0;
    lt_ba = ($signed(vb) < $signed(va)) ? 32'd1 : 32'd0;
    // R4 arithmetic results, R5 loads feed them, R6 stores bring them out
    chk("R4 add", mem[40], va + vb);
    chk("R4 sub", mem[41], va - vb);
    chk("R4 and", mem[42], va & vb);
    chk("R4 or",  mem[43], va | vb);
    chk("R10 slt a<b", mem[44], lt_ab);
    chk("R10 slt b<a", mem[45], lt_ba);
    chk("R8 reg0 stays zero", mem[46], 32'h0);
    // R7 branch on A==B skips the store at word 17
    chk("R7 cond branch", mem[47], (va == vb) ? SENT : va);
    chk("R7 taken branch skip", mem[48], SENT);
    // R9 unknown opcode has no effect; next store still happens
    chk("R9 after unknown op", mem[49], vb);
    // Cycle budget: lw 5, R-type 4, sw 4, beq 3, unknown 2 (R2 R5 R6 R7 R9)
    exp_halt = (va == vb) ? 78 : 82;
    chk("R5 R6 R7 R9 cycle count", 32'(halt_cyc), 32'(exp_halt));
  endtask

  initial begin
    #1;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    #20;
    // R1: reset state at the port
    chk("R1 reset addr", mem_addr, 32'h0);
    chk("R1 reset we", {31'd0, mem_we}, 32'h0);
    run_pair(32'd5, 32'd3);
    run_pair(32'd3, 32'd5);
    run_pair(-32'sd7, 32'd2);
    run_pair(32'h7FFF_FFFF, 32'hFFFF_FFFF);
    run_pair(32'h8000_0000, 32'd1);
    run_pair(32'd9, 32'd9);
    run_pair(32'h0, 32'h0);
    run_pair(32'hF0F0_1234, 32'h0FF0_8765);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule